// File: doc/BRIEF.md
# Audio Stream Descriptor-List Walker

This block steps through a circular list of 16-byte buffer descriptors in memory on behalf of one audio stream. It fetches descriptors through a single-beat read port. It holds the current descriptor index, the byte offset inside that descriptor and a link position counter that wraps at the cyclic buffer length. It answers each byte request from the audio side with a grant that respects every applicable limit.

Granted bytes are reported into the link position only once a FIFO watermark's worth has gathered. The block also reports any remainder that exactly fills the cyclic buffer. When a descriptor ends, or the cyclic buffer ends, and no remainder is pending, it sets a sticky completion status if that descriptor asked for it. It then pulses an interrupt request when interrupts are enabled. Every change of the link position can be mirrored to memory through a write-back request.

The walker does nothing while its run control is clear or the list base is zero. It refuses to grant while the watermark code is illegal.

Top module: `bdlWalker`

## Requirements
- R1: With `runEn` low or `listBase` zero, `memReq` and `grantValid` stay low, and `lpib` and `curIdx` do not change, whatever the requests.
- R2: A descriptor is read at `listBase + curIdx*16`. `memData` carries the buffer address in bits 63:0, the length in bits 95:64 and the completion flag in bit 96.
- R3: When the in-descriptor offset reaches the descriptor length, the offset returns to 0 and `curIdx` advances. From `lastIdx` it wraps to 0.
- R4: `lpib` never exceeds `cycLen` and returns to 0 in the cycle it would equal `cycLen`.
- R5: A descriptor is fetched after reset and again only after a transfer that hits the descriptor end or the cyclic-buffer end. A cyclic-end-only hit re-reads the same index and keeps the offset.
- R6: `grantBytes` is the least of `reqBytes`, the bytes left in the descriptor, `cycLen - lpib - pending` and `fifoSize + 1`. `grantAddr` is the descriptor address plus the offset.
- R7: Granted bytes join a pending remainder. `lpib` advances by the whole remainder only when it reaches the watermark or makes `lpib` equal `cycLen`. `wmCode` 0, 1 and 2 select 8, 16 and 32 bytes.
- R8: `wmCode` 3 is illegal: `cfgErr` is high while running and no grant is given.
- R9: A transfer that hits a descriptor end or the cyclic end with no remainder left sets `bufDone` if the current descriptor's flag is set. `irq` pulses for one cycle in the same case only when `intEnable` is high. `doneClr` clears `bufDone`, and a new set wins over it.
- R10: `fifoReady` is high in exactly the cycles that carry a grant.
- R11: With `posWbEnable` high, every change of `lpib` produces a one-cycle `posWbValid` carrying the new `lpib` at `posWbBase + streamNum*8`. With it low, no write-back is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Stream run control |
| intEnable | input | 1 | Interrupt enable for completion |
| listBase | input | ADDR_W | Descriptor list base address |
| cycLen | input | LEN_W | Cyclic buffer length in bytes |
| lastIdx | input | IDX_W | Last valid descriptor index |
| fifoSize | input | FS_W | FIFO size value (cap is this plus one) |
| wmCode | input | 2 | Watermark code |
| posWbEnable | input | 1 | Position write-back enable |
| posWbBase | input | ADDR_W | Position write-back base address |
| streamNum | input | 3 | Stream number |
| doneClr | input | 1 | Clears the completion status |
| memReq | output | 1 | Descriptor read request |
| memAddr | output | ADDR_W | Descriptor read address |
| memValid | input | 1 | Descriptor data valid |
| memData | input | 128 | Descriptor contents |
| reqValid | input | 1 | Audio side requests bytes |
| reqBytes | input | LEN_W | Bytes the audio side can take |
| grantValid | output | 1 | Grant issued this cycle |
| grantBytes | output | LEN_W | Bytes granted |
| grantAddr | output | 64 | Buffer address of the grant |
| fifoReady | output | 1 | Transfer cycle in progress |
| lpib | output | LEN_W | Link position counter |
| curIdx | output | IDX_W | Current descriptor index |
| bufDone | output | 1 | Sticky buffer-completion status |
| irq | output | 1 | Interrupt request pulse |
| posWbValid | output | 1 | Position write-back request |
| posWbAddr | output | ADDR_W | Position write-back address |
| posWbData | output | 32 | Position value to write |
| cfgErr | output | 1 | Illegal watermark code while running |

## Verification
The hardest case is the one where the cyclic buffer ends partway through a descriptor while a below-watermark remainder is pending. Only that case triggers the flush rule, the same-index re-read and the completion decision all at once. The stimulus reaches it by sweeping every legal watermark and two FIFO caps against a cyclic length that is, and one that is not, the sum of the descriptor lengths. Request sizes cycle through a pattern coprime to the descriptor lengths, so the buffer edges land at many different offsets.

// File: rtl/bdl_pkg.sv
package bdl_pkg;
  localparam int DESC_BYTES = 16;
  localparam int DESC_BITS  = DESC_BYTES * 8;

  typedef struct packed {
    logic loadDesc;
    logic doXfer;
  } bdlStrobe_t;

  function automatic logic wmLegal(input logic [1:0] code);
    return code != 2'd3;
  endfunction

  function automatic logic [5:0] wmBytes(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd8;
      2'd1:    return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [31:0] minU(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/bdlCtrl.sv
module bdlCtrl import bdl_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runOk,
  input  logic       cfgErr,
  input  logic       descValid,
  input  logic       memValid,
  input  logic       reqValid,
  input  logic       reqNz,
  input  logic       edgeNext,
  output logic       memReq,
  output bdlStrobe_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_ACTIVE} ctrlState_t;
  ctrlState_t state, nxt;

  always_comb begin
    nxt    = state;
    strb   = '0;
    memReq = 1'b0;
    case (state)
      ST_IDLE:  if (runOk) nxt = descValid ? ST_ACTIVE : ST_FETCH;
      ST_FETCH: begin
        memReq = 1'b1;
        if (memValid) begin
          strb.loadDesc = 1'b1;
          nxt = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (!descValid) nxt = ST_FETCH;
        else if (reqValid && reqNz && !cfgErr) begin
          strb.doXfer = 1'b1;
          if (edgeNext) nxt = ST_FETCH;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (!runOk) begin
      nxt    = ST_IDLE;
      strb   = '0;
      memReq = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    !runOk |=> (state == ST_IDLE)); // R1
endmodule

// File: rtl/bdlDatapath.sv
module bdlDatapath import bdl_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int IDX_W  = 8,
  parameter int FS_W   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bdlStrobe_t           strb,
  input  logic                 runEn,
  input  logic                 intEnable,
  input  logic                 posWbEnable,
  input  logic                 doneClr,
  input  logic                 memValid,
  input  logic [DESC_BITS-1:0] memData,
  input  logic [ADDR_W-1:0]    listBase,
  input  logic [LEN_W-1:0]     cycLen,
  input  logic [IDX_W-1:0]     lastIdx,
  input  logic [FS_W-1:0]      fifoSize,
  input  logic [1:0]           wmCode,
  input  logic [LEN_W-1:0]     reqBytes,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 descValid,
  output logic                 edgeNext,
  output logic [LEN_W-1:0]     grantBytes,
  output logic [63:0]          grantAddr,
  output logic [LEN_W-1:0]     lpib,
  output logic [IDX_W-1:0]     curIdx,
  output logic                 bufDone,
  output logic                 irq,
  output logic                 posWbValid
);
  localparam int CW = LEN_W + 1;

  logic [IDX_W-1:0] idxQ;
  logic [LEN_W-1:0] offQ, lenQ, lpibQ, underQ;
  logic [63:0]      addrQ;
  logic             iocQ, validQ, doneQ, irqQ, wbQ;

  logic [CW-1:0] remD, remC, capF, nCnt, pend, newOff, lpibSum, lpibAdd, underNew;
  logic          reachC, report, endD, endC, fire;
  logic          unusedRsvd;

  assign unusedRsvd = ^{memData[DESC_BITS-1:97], memData[95:64+LEN_W]};

  always_comb begin
    remD     = CW'(lenQ) - CW'(offQ);
    remC     = CW'(cycLen) - CW'(lpibQ) - CW'(underQ);
    capF     = CW'(fifoSize) + CW'(1);
    nCnt     = CW'(minU(minU(32'(reqBytes), 32'(remD)), minU(32'(remC), 32'(capF))));
    pend     = CW'(underQ) + nCnt;
    newOff   = CW'(offQ) + nCnt;
    lpibSum  = CW'(lpibQ) + pend;
    reachC   = (lpibSum == CW'(cycLen));
    report   = (pend >= CW'(wmBytes(wmCode))) || reachC;
    lpibAdd  = report ? lpibSum : CW'(lpibQ);
    underNew = report ? '0 : pend;
    endD     = (newOff == CW'(lenQ));
    endC     = (lpibAdd == CW'(cycLen));
    edgeNext = endD || endC;
    fire     = edgeNext && (underNew == '0) && iocQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0; offQ <= '0; lenQ <= '0; lpibQ <= '0; underQ <= '0;
      addrQ <= '0; iocQ <= 1'b0; validQ <= 1'b0;
      doneQ <= 1'b0; irqQ <= 1'b0; wbQ <= 1'b0;
    end else begin
      irqQ <= 1'b0;
      wbQ  <= 1'b0;
      if (doneClr) doneQ <= 1'b0;
      if (strb.loadDesc) begin
        addrQ  <= memData[63:0];
        lenQ   <= memData[64 +: LEN_W];
        iocQ   <= memData[96];
        validQ <= 1'b1;
      end
      if (strb.doXfer) begin
        offQ   <= endD ? '0 : newOff[LEN_W-1:0];
        if (endD) idxQ <= (idxQ == lastIdx) ? '0 : idxQ + 1'b1;
        lpibQ  <= endC ? '0 : lpibAdd[LEN_W-1:0];
        underQ <= underNew[LEN_W-1:0];
        validQ <= !edgeNext;
        irqQ   <= fire && intEnable;
        wbQ    <= posWbEnable && report;
        if (fire) doneQ <= 1'b1;
      end
    end
  end

  assign memAddr    = listBase + ADDR_W'({idxQ, 4'b0000});
  assign descValid  = validQ;
  assign grantBytes = nCnt[LEN_W-1:0];
  assign grantAddr  = addrQ + 64'(offQ);
  assign lpib       = lpibQ;
  assign curIdx     = idxQ;
  assign bufDone    = doneQ;
  assign irq        = irqQ;
  assign posWbValid = wbQ;

  AST_OFFSET_IN_DESC: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> (offQ <= lenQ)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN || !runEn)
    (32'(lpibQ) + 32'(underQ)) <= 32'(cycLen)); // R4
  AST_FETCH_BEFORE_USE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validQ) |-> $past(memValid)); // R5
  AST_IRQ_HAS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> doneQ); // R9
endmodule

// File: rtl/bdlWalker.sv
module bdlWalker import bdl_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int IDX_W  = 8,
  parameter int FS_W   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 runEn,
  input  logic                 intEnable,
  input  logic [ADDR_W-1:0]    listBase,
  input  logic [LEN_W-1:0]     cycLen,
  input  logic [IDX_W-1:0]     lastIdx,
  input  logic [FS_W-1:0]      fifoSize,
  input  logic [1:0]           wmCode,
  input  logic                 posWbEnable,
  input  logic [ADDR_W-1:0]    posWbBase,
  input  logic [2:0]           streamNum,
  input  logic                 doneClr,
  output logic                 memReq,
  output logic [ADDR_W-1:0]    memAddr,
  input  logic                 memValid,
  input  logic [DESC_BITS-1:0] memData,
  input  logic                 reqValid,
  input  logic [LEN_W-1:0]     reqBytes,
  output logic                 grantValid,
  output logic [LEN_W-1:0]     grantBytes,
  output logic [63:0]          grantAddr,
  output logic                 fifoReady,
  output logic [LEN_W-1:0]     lpib,
  output logic [IDX_W-1:0]     curIdx,
  output logic                 bufDone,
  output logic                 irq,
  output logic                 posWbValid,
  output logic [ADDR_W-1:0]    posWbAddr,
  output logic [31:0]          posWbData,
  output logic                 cfgErr
);
  bdlStrobe_t strb;
  logic runOk, descValid, edgeNext;

  assign runOk  = runEn && (listBase != '0);
  assign cfgErr = runEn && !wmLegal(wmCode);

  bdlCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .runOk(runOk), .cfgErr(cfgErr),
    .descValid(descValid), .memValid(memValid), .reqValid(reqValid),
    .reqNz(reqBytes != '0), .edgeNext(edgeNext), .memReq(memReq), .strb(strb)
  );

  bdlDatapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W), .FS_W(FS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .runEn(runEn), .intEnable(intEnable),
    .posWbEnable(posWbEnable), .doneClr(doneClr), .memValid(memValid),
    .memData(memData), .listBase(listBase), .cycLen(cycLen), .lastIdx(lastIdx),
    .fifoSize(fifoSize), .wmCode(wmCode), .reqBytes(reqBytes), .memAddr(memAddr),
    .descValid(descValid), .edgeNext(edgeNext), .grantBytes(grantBytes),
    .grantAddr(grantAddr), .lpib(lpib), .curIdx(curIdx), .bufDone(bufDone),
    .irq(irq), .posWbValid(posWbValid)
  );

  assign grantValid = strb.doXfer;
  assign fifoReady  = strb.doXfer;
  assign posWbAddr  = posWbBase + ADDR_W'({streamNum, 3'b000});
  assign posWbData  = 32'(lpib);
endmodule

// File: tb/bdlWalker_tb.sv
module bdlWalker_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, runEn = 1'b0, intEnable = 1'b0, posWbEnable = 1'b0, doneClr = 1'b0;
  logic [31:0] listBase = 32'h4000, posWbBase = 32'h8000_0000;
  logic [15:0] cycLen = 16'd144, reqBytes = '0;
  logic [7:0]  lastIdx = 8'd3, fifoSize = 8'd15;
  logic [1:0]  wmCode = 2'd0;
  logic [2:0]  streamNum = 3'd5;
  logic        memReq, memValid = 1'b0, reqValid = 1'b0;
  logic [31:0] memAddr, posWbAddr, posWbData;
  logic [127:0] memData = '0;
  logic        grantValid, fifoReady, bufDone, irq, posWbValid, cfgErr;
  logic [15:0] grantBytes, lpib;
  logic [63:0] grantAddr;
  logic [7:0]  curIdx;

  bdlWalker u_dut (.*);

  int nChecks = 0, nFails = 0;
  int mIdx, mOff, mLen, mIoc, mLpib, mUnder, mValid, expDone;
  longint mAddr;

  function automatic int lenOf(int i); return 24 + 8 * i; endfunction
  function automatic longint addrOf(int i); return 64'h1000_0000 + 64'(i) * 256; endfunction

  // descriptor memory: one-cycle read latency
  always @(posedge clk) begin
    if (memReq && !memValid) begin
      int i;
      i = (memAddr - listBase) / 16;
      memValid <= 1'b1;
      memData  <= {31'b0, 1'(i % 2), 32'(lenOf(i)), addrOf(i)};
    end else memValid <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic startCfg(input int code, input int fs, input int cbl, input bit ie, input bit wb);
    @(negedge clk);
    rstN = 1'b0; runEn = 1'b0; reqValid = 1'b0;
    wmCode = 2'(code); fifoSize = 8'(fs); cycLen = 16'(cbl); intEnable = ie; posWbEnable = wb;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1; runEn = 1'b1;
    mIdx = 0; mOff = 0; mLen = 0; mIoc = 0; mLpib = 0; mUnder = 0; mValid = 0; expDone = 0; mAddr = 0;
  endtask

  task automatic xfer(input int req);
    bit got = 0;
    int tries = 0, n, pend, wm, endD, endC, rep, fire, eIrq, eWb;
    reqValid = 1'b1; reqBytes = 16'(req);
    eIrq = 0; eWb = 0;
    while (!got && tries < 20) begin
      #1;
      if (memReq) chk(memAddr == listBase + 32'(mIdx * 16), "R2 fetch address", memAddr, listBase + mIdx * 16);
      if (grantValid) begin
        if (!mValid) begin mLen = lenOf(mIdx); mIoc = mIdx % 2; mAddr = addrOf(mIdx); mValid = 1; end
        n = req;
        if (mLen - mOff < n) n = mLen - mOff;
        if (cycLen - mLpib - mUnder < n) n = cycLen - mLpib - mUnder;
        if (fifoSize + 1 < n) n = fifoSize + 1;
        chk(grantBytes == 16'(n), "R6 grant bytes", grantBytes, n);
        chk(grantAddr == mAddr + 64'(mOff), "R6 grant address", grantAddr, mAddr + mOff);
        chk(fifoReady == 1'b1, "R10 fifo ready in grant", fifoReady, 1);
        wm = 8 << wmCode;
        pend = mUnder + n;
        mOff += n;
        rep = (pend >= wm) || (mLpib + pend == cycLen);
        if (rep) begin mLpib += pend; mUnder = 0; end else mUnder = pend;
        endD = (mOff == mLen); endC = (mLpib == cycLen);
        fire = (endD || endC) && (mUnder == 0) && mIoc;
        if (fire) expDone = 1;
        eIrq = fire && intEnable;
        eWb = rep && posWbEnable;
        if (endC) mLpib = 0;
        if (endD) begin mOff = 0; mIdx = (mIdx == lastIdx) ? 0 : mIdx + 1; end
        if (endD || endC) mValid = 0;
        got = 1;
      end else if (!memReq) begin
        chk(fifoReady == 1'b0, "R10 fifo ready idle", fifoReady, 0);
      end
      @(negedge clk);
      tries++;
    end
    reqValid = 1'b0;
    chk(got, "R5 grant reached", got, 1);
    chk(lpib == 16'(mLpib), "R4 R7 link position", lpib, mLpib);
    chk(curIdx == 8'(mIdx), "R3 descriptor index", curIdx, mIdx);
    chk(irq == 1'(eIrq), "R9 interrupt pulse", irq, eIrq);
    chk(bufDone == 1'(expDone), "R9 completion status", bufDone, expDone);
    chk(posWbValid == 1'(eWb), "R11 write-back request", posWbValid, eWb);
    if (eWb) begin
      chk(posWbData == 32'(mLpib), "R11 write-back data", posWbData, mLpib);
      chk(posWbAddr == 32'h8000_0028, "R11 write-back address", posWbAddr, 32'h8000_0028);
    end
  endtask

  initial begin
    #(200000 * 20);
    nFails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", nChecks - nFails + 1, nChecks + 1);
    $finish;
  end

  initial begin
    int fsv[2] = '{3, 15};
    int cbv[2] = '{144, 100};
    // reset state and idle with run clear (R1)
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    reqValid = 1'b1; reqBytes = 16'd8;
    repeat (4) begin
      @(negedge clk);
      chk(memReq == 1'b0 && grantValid == 1'b0, "R1 run clear", {memReq, grantValid}, 0);
    end
    chk(lpib == 0 && curIdx == 0 && bufDone == 0, "R1 reset state", lpib, 0);
    reqValid = 1'b0;
    // zero list base keeps the walker idle (R1)
    listBase = '0; runEn = 1'b1; reqValid = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(memReq == 1'b0 && grantValid == 1'b0, "R1 zero base", {memReq, grantValid}, 0);
    end
    reqValid = 1'b0; runEn = 1'b0; listBase = 32'h4000;

    // sweep legal watermarks, FIFO caps and cyclic lengths
    for (int code = 0; code < 3; code++)
      for (int f = 0; f < 2; f++)
        for (int c = 0; c < 2; c++) begin
          startCfg(code, fsv[f], cbv[c], (f + c) % 2 == 0, (code + c) % 2 == 1);
          for (int k = 0; k < 40; k++) xfer(1 + (k * 7) % 13);
          if (bufDone) begin
            doneClr = 1'b1; @(negedge clk); doneClr = 1'b0;
            chk(bufDone == 1'b0, "R9 status clear", bufDone, 0);
            expDone = 0;
          end
          // stopping the run freezes position (R1)
          runEn = 1'b0; reqValid = 1'b1; reqBytes = 16'd5;
          repeat (3) begin
            @(negedge clk);
            chk(grantValid == 1'b0 && lpib == 16'(mLpib), "R1 stopped", lpib, mLpib);
          end
          reqValid = 1'b0;
        end

    // illegal watermark code (R8)
    startCfg(3, 15, 144, 1'b1, 1'b1);
    reqValid = 1'b1; reqBytes = 16'd10;
    repeat (6) begin
      @(negedge clk);
      chk(cfgErr == 1'b1 && grantValid == 1'b0, "R8 illegal watermark", {cfgErr, grantValid}, 2);
    end
    chk(lpib == 0, "R8 position held", lpib, 0);
    reqValid = 1'b0;

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule